// File: doc/BRIEF.md
# Two-Channel Memory Copy Engine

The engine copies data from a source address to a destination address on a simple synchronous memory bus. Two independent channels each hold a source address, a destination address, a remaining-unit count and a control word. Each control word sets the unit size (byte, halfword or word), the run mode and the address-hold options. A channel becomes pending when software writes its control word with the start bit set, or when the hardware request line chosen by its select field is high while the channel is enabled.

A shared arbiter picks the next channel. It uses either fixed priority or alternating priority, chosen by one global bit. A single data mover then issues a read cycle at the source address and a write cycle at the destination address, in that order. In steal mode the mover hands the bus back after every unit. In burst mode the granted channel keeps the bus until its count runs out. When the final unit of a channel is written, the channel disables itself, sets a sticky done bit and raises its interrupt line. The line stays high until software clears the done bit.

Configuration is word-indexed on `cfg_addr`. Channel c uses index 4c+0 for the source, 4c+1 for the destination, 4c+2 for the count and 4c+3 for the control word. Index 8 holds the priority mode in bit 0 (0 fixed, 1 alternating). Memory reads return data on `mem_rdata` in the cycle after the read request.

Top module: `dma2ch`

## Requirements
- R1: After reset every configuration register reads zero, both interrupt lines are low and `mem_req` is low.
- R2: Each unit is a read cycle (`mem_req`=1, `mem_we`=0) at the source address, followed in the next cycle by a write cycle at the destination address that carries the word read. `mem_size` gives the unit: 0 byte, 1 halfword, 2 word.
- R3: A count value C moves C+1 units, so 16'hFFFF stands for 65,536. The count register reads back the number of units still to go after the current one, and it drops by one after every unit except the last.
- R4: After each unit the source and destination addresses each advance by the unit size in bytes (1, 2 or 4). Control bit 5 holds the source address and control bit 6 holds the destination address.
- R5: In steal mode (control bit 2 = 0) each request moves exactly one unit. The bus is then idle for at least one cycle.
- R6: In burst mode (control bit 2 = 1) one request moves all remaining units back to back, one unit every two cycles.
- R7: With the mode bit at 0, channel 0 is served first when both channels are pending.
- R8: With the mode bit at 1, the channel that was not granted last is served first when both are pending.
- R9: On its final unit a channel clears its enable (control bit 0) and sets done (control bit 15), and its `irq` line goes high. Writing a control word with bit 15 set clears done. If the clear lands in the same cycle as a completion, done stays set.
- R10: A hardware request counts only when the channel is enabled and the line is the one named by control bits 8:7. Other lines, and requests to a disabled channel, cause no bus activity.
- R11: A control write with enable (bit 0) and start (bit 1) both set makes the channel pending. Start always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational from `cfg_addr` |
| hw_req | input | NSRC | Hardware request lines |
| mem_req | output | 1 | Bus cycle valid |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Unit size code |
| mem_wdata | output | 32 | Write data, low lanes used |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| irq | output | 2 | Per-channel completion interrupt |

## Verification
Two events can fall in the same cycle, and the bench provokes both. In the first, both channels become pending at the same clock edge: one pulse drives both selected hardware lines together, and the log of destination addresses shows which channel the mover served first, under fixed priority and again under alternating priority after a known grant history. In the second, a software clear of done arrives in exactly the write cycle of a channel's final unit. The bench judges this by reading the done bit and the interrupt line afterwards, and both must still be set.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } mv_state_e;

    localparam int CB_EN    = 0;
    localparam int CB_START = 1;
    localparam int CB_BURST = 2;
    localparam int CB_SIZE  = 3;
    localparam int CB_HSRC  = 5;
    localparam int CB_HDST  = 6;
    localparam int CB_SEL   = 7;
    localparam int CB_DONE  = 15;
endpackage

// File: rtl/dma_arbiter.sv
module dma_arbiter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       rr_mode,
    input  logic       take,
    output logic       gnt_valid,
    output logic       gnt_idx
);
    logic last_d, last_q;

    always_comb begin
        gnt_valid = |req;
        if (req == 2'b11) gnt_idx = rr_mode ? ~last_q : 1'b0;
        else              gnt_idx = ~req[0];
        last_d = take ? gnt_idx : last_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= last_d;
    end

    // R7
    fixed_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rr_mode && req[0]) |=> !last_q);
    // R8
    rr_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && rr_mode && req == 2'b11) |=> (last_q != $past(last_q)));
endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CW   = 16,
    parameter int NSRC = 4,
    localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_src,
    input  logic            wr_dst,
    input  logic            wr_cnt,
    input  logic            wr_ctrl,
    input  logic [31:0]     wdata,
    input  logic [NSRC-1:0] hw_req,
    input  logic            unit_done,
    output logic            req,
    output logic [AW-1:0]   src,
    output logic [AW-1:0]   dst,
    output logic [CW-1:0]   cnt,
    output logic [1:0]      size,
    output logic            burst,
    output logic            last,
    output logic            done,
    output logic [31:0]     ctrl_rd
);
    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [SW-1:0] sel;
        logic [1:0]    size;
        logic          en;
        logic          burst;
        logic          hsrc;
        logic          hdst;
        logic          pend;
        logic          done;
    } ch_t;

    ch_t d, q;
    logic [AW-1:0] step;
    logic          hw_hit;

    always_comb begin
        d = q;
        case (q.size)
            2'd0:    step = AW'(1);
            2'd1:    step = AW'(2);
            default: step = AW'(4);
        endcase
        hw_hit = q.en && hw_req[q.sel];
        if (hw_hit) d.pend = 1'b1;
        if (wr_src) d.src = wdata[AW-1:0];
        if (wr_dst) d.dst = wdata[AW-1:0];
        if (wr_cnt) d.cnt = wdata[CW-1:0];
        if (wr_ctrl) begin
            d.en    = wdata[CB_EN];
            d.burst = wdata[CB_BURST];
            d.size  = wdata[CB_SIZE +: 2];
            d.hsrc  = wdata[CB_HSRC];
            d.hdst  = wdata[CB_HDST];
            d.sel   = wdata[CB_SEL +: SW];
            if (wdata[CB_EN] && wdata[CB_START]) d.pend = 1'b1;
            if (!wdata[CB_EN])                   d.pend = 1'b0;
            if (wdata[CB_DONE])                  d.done = 1'b0;
        end
        if (unit_done) begin
            if (q.cnt == '0) begin
                d.en   = 1'b0;
                d.pend = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt - CW'(1);
                if (!q.hsrc) d.src = q.src + step;
                if (!q.hdst) d.dst = q.dst + step;
                if (!q.burst) d.pend = hw_hit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        req   = q.pend && q.en;
        src   = q.src;
        dst   = q.dst;
        cnt   = q.cnt;
        size  = q.size;
        burst = q.burst;
        last  = (q.cnt == '0);
        done  = q.done;
        ctrl_rd                = '0;
        ctrl_rd[CB_EN]         = q.en;
        ctrl_rd[CB_BURST]      = q.burst;
        ctrl_rd[CB_SIZE +: 2]  = q.size;
        ctrl_rd[CB_HSRC]       = q.hsrc;
        ctrl_rd[CB_HDST]       = q.hdst;
        ctrl_rd[CB_SEL +: SW]  = q.sel;
        ctrl_rd[CB_DONE]       = q.done;
    end

    // R9
    done_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> !q.en);
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && q.cnt != '0 && !wr_cnt) |=> (q.cnt == $past(q.cnt) - CW'(1)));
    // R4
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && q.hsrc && !wr_src) |=> $stable(q.src));
endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gnt_valid,
    input  logic                gnt_idx,
    input  logic [1:0][AW-1:0]  ch_src,
    input  logic [1:0][AW-1:0]  ch_dst,
    input  logic [1:0][1:0]     ch_size,
    input  logic [1:0]          ch_burst,
    input  logic [1:0]          ch_last,
    input  logic [1:0]          ch_req,
    input  logic [31:0]         mem_rdata,
    output logic                take,
    output logic [1:0]          unit_done,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [1:0]          mem_size,
    output logic [31:0]         mem_wdata
);
    typedef struct packed {
        mv_state_e st;
        logic      own;
    } mv_t;

    mv_t d, q;

    always_comb begin
        d         = q;
        take      = 1'b0;
        unit_done = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_size  = ch_size[q.own];
        case (q.st)
            ST_IDLE: begin
                if (gnt_valid) begin
                    take  = 1'b1;
                    d.own = gnt_idx;
                    d.st  = ST_RD;
                end
            end
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = ch_src[q.own];
                d.st     = ST_WR;
            end
            ST_WR: begin
                mem_req            = 1'b1;
                mem_we             = 1'b1;
                mem_addr           = ch_dst[q.own];
                mem_wdata          = mem_rdata;
                unit_done[q.own]   = 1'b1;
                d.st = (ch_burst[q.own] && !ch_last[q.own] && ch_req[q.own]) ? ST_RD : ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, own: 1'b0};
        else        q <= d;
    end

    // R2
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we));
    // R5
    steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|unit_done && !ch_burst[q.own]) |=> !mem_req);
endmodule

// File: rtl/dma2ch.sv
module dma2ch
    import dma_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CW   = 16,
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [3:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    output logic [31:0]     cfg_rdata,
    input  logic [NSRC-1:0] hw_req,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [1:0]      mem_size,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    output logic [1:0]      irq
);
    localparam int NCH = 2;

    logic [NCH-1:0][AW-1:0] ch_src, ch_dst;
    logic [NCH-1:0][CW-1:0] ch_cnt;
    logic [NCH-1:0][1:0]    ch_size;
    logic [NCH-1:0][31:0]   ch_ctrl;
    logic [NCH-1:0]         ch_req, ch_burst, ch_last, ch_done, unit_done;
    logic                   gnt_valid, gnt_idx, take;
    logic                   mode_d, mode_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = cfg_we && !cfg_addr[3] && (cfg_addr[2] == 1'(c));
        dma_channel #(.AW(AW), .CW(CW), .NSRC(NSRC)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_src    (hit && cfg_addr[1:0] == 2'd0),
            .wr_dst    (hit && cfg_addr[1:0] == 2'd1),
            .wr_cnt    (hit && cfg_addr[1:0] == 2'd2),
            .wr_ctrl   (hit && cfg_addr[1:0] == 2'd3),
            .wdata     (cfg_wdata),
            .hw_req    (hw_req),
            .unit_done (unit_done[c]),
            .req       (ch_req[c]),
            .src       (ch_src[c]),
            .dst       (ch_dst[c]),
            .cnt       (ch_cnt[c]),
            .size      (ch_size[c]),
            .burst     (ch_burst[c]),
            .last      (ch_last[c]),
            .done      (ch_done[c]),
            .ctrl_rd   (ch_ctrl[c])
        );
    end

    dma_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ch_req),
        .rr_mode   (mode_q),
        .take      (take),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    dma_mover #(.AW(AW)) u_mv (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx),
        .ch_src    (ch_src),
        .ch_dst    (ch_dst),
        .ch_size   (ch_size),
        .ch_burst  (ch_burst),
        .ch_last   (ch_last),
        .ch_req    (ch_req),
        .mem_rdata (mem_rdata),
        .take      (take),
        .unit_done (unit_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata)
    );

    always_comb begin
        mode_d = (cfg_we && cfg_addr == 4'h8) ? cfg_wdata[0] : mode_q;
        cfg_rdata = '0;
        if (cfg_addr[3]) begin
            if (cfg_addr[2:0] == 3'd0) cfg_rdata[0] = mode_q;
        end else begin
            case (cfg_addr[1:0])
                2'd0:    cfg_rdata = 32'(ch_src[cfg_addr[2]]);
                2'd1:    cfg_rdata = 32'(ch_dst[cfg_addr[2]]);
                2'd2:    cfg_rdata = 32'(ch_cnt[cfg_addr[2]]);
                default: cfg_rdata = ch_ctrl[cfg_addr[2]];
            endcase
        end
        irq = ch_done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_d;
    end

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[0] && !(cfg_we && cfg_addr == 4'h3 && cfg_wdata[CB_DONE])) |=> irq[0]);
endmodule

// File: tb/dma2ch_test.sv
module dma2ch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  hw_req = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size, irq;

    dma2ch uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hw_req(hw_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq(irq)
    );

    always #10 clk = ~clk;

    // bench memory, write log
    logic [7:0]  mem [256];
    logic [31:0] rdata_q;
    logic [7:0]  a0;
    int          wcnt, cyc;
    logic [7:0]  wlog_addr [64];
    logic [1:0]  wlog_size [64];
    int          wlog_cyc  [64];
    assign a0 = mem_addr[7:0];
    assign mem_rdata = rdata_q;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 29 + 3);
            wcnt    <= 0;
            rdata_q <= '0;
        end else if (mem_req) begin
            if (!mem_we) begin
                rdata_q <= {mem[a0 + 8'd3], mem[a0 + 8'd2], mem[a0 + 8'd1], mem[a0]};
            end else begin
                for (int b = 0; b < 4; b++)
                    if (b < (mem_size == 2'd0 ? 1 : mem_size == 2'd1 ? 2 : 4))
                        mem[8'(a0 + 8'(b))] <= mem_wdata[8*b +: 8];
                if (wcnt < 64) begin
                    wlog_addr[wcnt] <= a0;
                    wlog_size[wcnt] <= mem_size;
                    wlog_cyc[wcnt]  <= cyc;
                end
                wcnt <= wcnt + 1;
            end
        end
    end

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    task automatic pulse(input logic [3:0] v);
        @(negedge clk); hw_req = v;
        @(negedge clk); hw_req = '0;
    endtask

    function automatic logic [31:0] ctl(bit en, bit st, bit bu, logic [1:0] sz,
                                        bit hs, bit hd, logic [1:0] sel, bit clr);
        logic [31:0] w = '0;
        w[0] = en; w[1] = st; w[2] = bu; w[4:3] = sz; w[5] = hs; w[6] = hd;
        w[8:7] = sel; w[15] = clr;
        return w;
    endfunction

    function automatic int nbytes(logic [1:0] sz);
        return sz == 2'd0 ? 1 : (sz == 2'd1 ? 2 : 4);
    endfunction

    logic [7:0] snap [256];
    logic [7:0] expm [256];

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int mark;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 9; a++) begin
            cfg_read(4'(a), rd);
            check(rd == 0, "R1 register reset", rd, 0);
        end
        check(irq == 2'b00 && !mem_req, "R1 irq/bus idle", {irq, mem_req}, 0);

        // R6 burst, R2 size, R4 advance, R9 completion
        for (int i = 0; i < 256; i++) snap[i] = mem[i];
        mark = wcnt;
        cfg_write(4'h0, 32'h10);
        cfg_write(4'h1, 32'h80);
        cfg_write(4'h2, 32'd3);
        cfg_write(4'h3, ctl(1, 1, 1, 2'd2, 0, 0, 2'd0, 0));   // R11 start
        repeat (30) @(negedge clk);
        check(wcnt - mark == 4, "R6 burst unit count", wcnt - mark, 4);
        check(wlog_cyc[mark+3] - wlog_cyc[mark] == 6, "R6 back to back", wlog_cyc[mark+3] - wlog_cyc[mark], 6);
        check(wlog_addr[mark+3] == 8'h8C, "R4 dst advance by 4", wlog_addr[mark+3], 8'h8C);
        check(wlog_size[mark] == 2'd2, "R2 size code", wlog_size[mark], 2);
        begin
            int bad = 0;
            for (int i = 0; i < 16; i++) if (mem[8'h80 + i] != snap[8'h10 + i]) bad++;
            check(bad == 0, "R2 copied data", bad, 0);
        end
        check(irq[0] == 1'b1, "R9 irq after final unit", irq, 1);
        cfg_read(4'h3, rd);
        check(rd[0] == 0 && rd[15] == 1 && rd[1] == 0, "R9 enable cleared done set", rd, 32'h8004 | 32'h10);
        cfg_read(4'h2, rd);
        check(rd == 0, "R3 count at end", rd, 0);
        cfg_write(4'h3, ctl(0, 0, 0, 0, 0, 0, 0, 1));
        check(irq[0] == 1'b0, "R9 write-1 clear", irq, 0);

        // R5 steal, R3 remaining, R4 dst hold
        for (int i = 0; i < 256; i++) snap[i] = mem[i];
        mark = wcnt;
        cfg_write(4'h4, 32'h20);
        cfg_write(4'h5, 32'hB0);
        cfg_write(4'h6, 32'd2);
        cfg_write(4'h7, ctl(1, 1, 0, 2'd0, 0, 1, 2'd0, 0));
        repeat (8) @(negedge clk);
        check(wcnt - mark == 1, "R5 one unit per request", wcnt - mark, 1);
        cfg_read(4'h6, rd);
        check(rd == 1, "R3 remaining after one unit", rd, 1);
        for (int k = 0; k < 2; k++) begin
            cfg_write(4'h7, ctl(1, 1, 0, 2'd0, 0, 1, 2'd0, 0));
            repeat (8) @(negedge clk);
        end
        check(wcnt - mark == 3 && wlog_addr[mark+2] == 8'hB0, "R4 dst held", wlog_addr[mark+2], 8'hB0);
        check(mem[8'hB0] == snap[8'h22] && mem[8'hB1] == snap[8'hB1], "R4 held dst data", mem[8'hB0], snap[8'h22]);
        check(irq[1] == 1'b1, "R9 ch1 irq", irq, 2);
        cfg_write(4'h7, ctl(0, 0, 0, 0, 0, 0, 0, 1));

        // R3 maximum count encoding
        cfg_write(4'h6, 32'hFFFF);
        cfg_write(4'h7, ctl(1, 1, 0, 2'd0, 0, 0, 2'd0, 0));
        repeat (8) @(negedge clk);
        cfg_read(4'h6, rd);
        check(rd == 32'hFFFE && irq[1] == 0, "R3 16-bit count", rd, 32'hFFFE);
        cfg_write(4'h7, 32'h0);

        // R10 hardware request gating
        cfg_write(4'h6, 32'd5);
        cfg_write(4'h7, ctl(0, 0, 0, 2'd0, 0, 0, 2'd2, 0));
        mark = wcnt;
        pulse(4'b0100);
        repeat (8) @(negedge clk);
        check(wcnt == mark, "R10 disabled channel ignores line", wcnt - mark, 0);
        cfg_write(4'h7, ctl(1, 0, 0, 2'd0, 0, 0, 2'd2, 0));
        pulse(4'b0010);
        repeat (8) @(negedge clk);
        check(wcnt == mark, "R10 unselected line ignored", wcnt - mark, 0);
        pulse(4'b0100);
        repeat (8) @(negedge clk);
        check(wcnt - mark == 1, "R10 selected line served", wcnt - mark, 1);

        // R7 fixed priority
        cfg_write(4'h1, 32'h90);
        cfg_write(4'h2, 32'd3);
        cfg_write(4'h3, ctl(1, 0, 0, 2'd0, 0, 0, 2'd0, 0));
        cfg_write(4'h5, 32'hA0);
        cfg_write(4'h6, 32'd3);
        cfg_write(4'h7, ctl(1, 0, 0, 2'd0, 0, 0, 2'd1, 0));
        mark = wcnt;
        pulse(4'b0011);
        repeat (12) @(negedge clk);
        check(wcnt - mark == 2 && wlog_addr[mark] == 8'h90 && wlog_addr[mark+1] == 8'hA0,
              "R7 channel 0 first", wlog_addr[mark], 8'h90);

        // R8 alternating priority
        cfg_write(4'h8, 32'd1);
        pulse(4'b0001);
        repeat (8) @(negedge clk);
        mark = wcnt;
        pulse(4'b0011);
        repeat (12) @(negedge clk);
        check(wcnt - mark == 2 && wlog_addr[mark] == 8'hA1 && wlog_addr[mark+1] == 8'h92,
              "R8 last winner yields", wlog_addr[mark], 8'hA1);
        cfg_write(4'h3, 32'h0);
        cfg_write(4'h7, 32'h0);
        cfg_write(4'h8, 32'd0);

        // R9 clear colliding with completion: done wins
        cfg_write(4'h2, 32'd0);
        cfg_write(4'h3, ctl(1, 1, 0, 2'd0, 0, 0, 2'd0, 1));
        @(negedge clk);
        cfg_write(4'h3, ctl(0, 0, 0, 2'd0, 0, 0, 2'd0, 1));
        cfg_read(4'h3, rd);
        check(rd[15] == 1 && irq[0] == 1, "R9 set beats clear", rd, 32'h8000);
        cfg_write(4'h3, ctl(0, 0, 0, 0, 0, 0, 0, 1));

        // random runs against bench model
        for (int it = 0; it < 8; it++) begin
            int ch = $urandom % 2;
            logic [1:0] sz = 2'($urandom % 3);
            int cn = $urandom % 6;
            bit bu = 1'($urandom % 2);
            bit hs = 1'($urandom % 2);
            bit hd = 1'($urandom % 2);
            int s0 = $urandom % 32;
            int d0 = 128 + ($urandom % 32);
            logic [3:0] base = 4'(ch * 4);
            int bad = 0;
            cfg_write(base, 32'(s0));
            cfg_write(base + 4'd1, 32'(d0));
            cfg_write(base + 4'd2, 32'(cn));
            for (int i = 0; i < 256; i++) begin snap[i] = mem[i]; expm[i] = mem[i]; end
            for (int u = 0; u <= cn; u++)
                for (int b = 0; b < nbytes(sz); b++)
                    expm[(hd ? d0 : d0 + u * nbytes(sz)) + b] = snap[(hs ? s0 : s0 + u * nbytes(sz)) + b];
            cfg_write(base + 4'd3, ctl(1, 1, bu, sz, hs, hd, 2'd3, 1));
            if (bu) repeat (30) @(negedge clk);
            else begin
                repeat (8) @(negedge clk);
                for (int k = 0; k < cn; k++) begin
                    cfg_write(base + 4'd3, ctl(1, 1, bu, sz, hs, hd, 2'd3, 0));
                    repeat (8) @(negedge clk);
                end
            end
            for (int i = 0; i < 256; i++) if (mem[i] != expm[i]) bad++;
            check(bad == 0, "R2 R4 random copy image", bad, 0);
            check(irq[ch] == 1'b1, "R9 random completion irq", irq, 2'(1 << ch));
            cfg_read(base + 4'd3, rd);
            check(rd[0] == 0 && rd[15] == 1, "R3 random unit total", rd[15:0], 16'h8000);
            cfg_write(base + 4'd3, ctl(0, 0, 0, 0, 0, 0, 0, 1));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule